// File: doc/BRIEF.md
# Pipeline Slip and Interlock Controller

This block decides, once per cycle, whether the instruction sitting in the register-fetch stage of a five-stage in-order pipeline (fetch, register fetch, execute, data-cache, write-back) may start or must slip. An instruction slips when one of its source registers is written by the instruction directly ahead of it, and that instruction produces its result only at the end of the data-cache stage. Such producers are loads and moves from HI, LO or coprocessor-0. An instruction also slips when it reads HI or LO while the multiply/divide unit is still working.

On a slip the block freezes fetch and register fetch, and places a no-op in the execute slot. The data-cache and write-back stages keep moving, so the late result comes one step closer every slipped cycle. The block keeps a small record of the destinations in execute and data-cache, filled from the register-fetch fields as instructions issue. From this record it drives a per-operand select that takes the data returned at the end of the data-cache stage into the end of register fetch. It also drives a select that takes a just-finished multiply/divide result into a HI/LO read.

Instructions cancelled by a branch-likely, an exception return or an exception never cause a slip. A producer cancelled while in execute leaves nothing behind to forward.

Top module: `slip_ctrl`

## Requirements
- R1: When the register-fetch instruction is valid, not killed, and reads through a valid source field a nonzero register, and the instruction issued in the previous cycle is a late-result producer with that destination and is not killed in execute this cycle, then stall_front_o and bubble_ex_o are both 1 in that cycle.
- R2: A load-type slip lasts exactly one cycle while the register-fetch fields are held. In the next cycle the instruction runs, and the byp_dc_o bit of each matching operand is 1 (bit i serves source i).
- R3: No slip occurs when the producer in execute is not a late-result producer, when the reader's sources differ from its destination, or when the matching source field is marked not valid.
- R4: Register 0 never creates a dependency or a bypass, and an issued instruction whose destination-valid bit is 0 never causes a slip or a bypass.
- R5: A late-result producer with exactly one instruction between it and a reader causes no slip, and sets byp_dc_o for each operand that reads its destination.
- R6: A producer whose ex_kill_i is 1 during its execute cycle causes no slip in that cycle, and no bypass in the following cycle.
- R7: A register-fetch instruction with rf_kill_i at 1 never slips and never gets a bypass select. It issues as nothing, so a later reader of its destination neither slips nor bypasses.
- R8: An instruction that reads HI or LO slips in every cycle in which md_busy_i is 1. The number of slipped cycles equals the number of busy cycles.
- R9: hilo_byp_o is 1 only in a cycle where a HI/LO-reading instruction runs while md_ready_i is 1.
- R10: During and right after reset no slip or bypass is reported, and all bypass outputs are 0 in slipped cycles and when register fetch is empty.
- R11: When both operands read the destination of a late-result producer in execute, the instruction slips once and then sets both bits of byp_dc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rf_valid_i | input | 1 | Register-fetch stage holds an instruction |
| rf_kill_i | input | 1 | Register-fetch instruction is cancelled |
| rf_src_i | input | NUM_SRC x REG_W | Source register numbers |
| rf_src_vld_i | input | NUM_SRC | Source field is used |
| rf_dst_i | input | REG_W | Destination register number |
| rf_dst_vld_i | input | 1 | Instruction writes a destination |
| rf_late_i | input | 1 | Result is ready only at end of data-cache stage |
| rf_rd_hilo_i | input | 1 | Instruction reads HI or LO |
| ex_kill_i | input | 1 | Instruction in execute is cancelled |
| md_busy_i | input | 1 | Multiply/divide unit is computing |
| md_ready_i | input | 1 | Multiply/divide result available this cycle |
| stall_front_o | output | 1 | Hold fetch and register fetch |
| bubble_ex_o | output | 1 | Load a no-op into execute |
| byp_dc_o | output | NUM_SRC | Per-operand select of data-cache return data |
| hilo_byp_o | output | 1 | Select the fresh multiply/divide result |

## Verification
The checker assumes that the surrounding pipeline honours a slip by presenting the same register-fetch fields on the next cycle. Its one-cycle-slip and bypass-after-slip properties rely on that. It also treats md_ready_i as a strobe that arrives when md_busy_i has dropped. The bench keeps to both assumptions. Its random driver holds every register-fetch field whenever its model predicts a slip. It runs the multiply/divide unit as a counter that asserts busy for one to four cycles and then gives a single ready pulse. Kill inputs are free to change in any cycle, and the properties allow for that.

// File: rtl/slip_pkg.sv
package slip_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE = 2'd0,
    SLIP_LOAD = 2'd1,
    SLIP_MD   = 2'd2
  } slip_cause_e;
endpackage

// File: rtl/slip_stage_track.sv
// Destination records of the stages behind register fetch; they always advance.
module slip_stage_track #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned DEPTH = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_vld_i,
  input  logic                        in_late_i,
  input  logic [REG_W-1:0]            in_dst_i,
  input  logic                        kill_head_i,
  output logic [DEPTH-1:0]            vld_o,
  output logic [DEPTH-1:0]            late_o,
  output logic [DEPTH-1:0][REG_W-1:0] dst_o
);
  logic [DEPTH-1:0]            vld_q, late_q, vld_d, late_d;
  logic [DEPTH-1:0][REG_W-1:0] dst_q, dst_d;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign vld_d[k]  = in_vld_i;
      assign late_d[k] = in_late_i;
      assign dst_d[k]  = in_dst_i;
    end else begin : g_tail
      // a kill in the head stage clears the entry as it moves on
      if (k == 1) begin : g_kill
        assign vld_d[k] = vld_q[k-1] & ~kill_head_i;
      end else begin : g_pass
        assign vld_d[k] = vld_q[k-1];
      end
      assign late_d[k] = late_q[k-1];
      assign dst_d[k]  = dst_q[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[k]  <= 1'b0;
        late_q[k] <= 1'b0;
        dst_q[k]  <= '0;
      end else begin
        vld_q[k]  <= vld_d[k];
        late_q[k] <= late_d[k];
        dst_q[k]  <= dst_d[k];
      end
    end
  end

  assign vld_o  = vld_q;
  assign late_o = late_q;
  assign dst_o  = dst_q;
endmodule

// File: rtl/slip_src_match.sv
module slip_src_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             src_vld_i,
  input  logic             ex_live_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic             dc_live_i,
  input  logic [REG_W-1:0] dc_dst_i,
  output logic             ex_dep_o,
  output logic             dc_hit_o
);
  logic used;
  // register 0 is hardwired, never a dependency
  assign used     = src_vld_i && (src_i != '0);
  assign ex_dep_o = used && ex_live_i && (src_i == ex_dst_i);
  assign dc_hit_o = used && dc_live_i && (src_i == dc_dst_i);
endmodule

// File: rtl/slip_ctrl.sv
module slip_ctrl
  import slip_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rf_valid_i,
  input  logic                          rf_kill_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] rf_src_i,
  input  logic [NUM_SRC-1:0]            rf_src_vld_i,
  input  logic [REG_W-1:0]              rf_dst_i,
  input  logic                          rf_dst_vld_i,
  input  logic                          rf_late_i,
  input  logic                          rf_rd_hilo_i,
  input  logic                          ex_kill_i,
  input  logic                          md_busy_i,
  input  logic                          md_ready_i,
  output logic                          stall_front_o,
  output logic                          bubble_ex_o,
  output logic [NUM_SRC-1:0]            byp_dc_o,
  output logic                          hilo_byp_o
);
  localparam int unsigned DEPTH  = 2;
  localparam int unsigned EX_IDX = 0;
  localparam int unsigned DC_IDX = 1;

  logic [DEPTH-1:0]            stg_vld, stg_late;
  logic [DEPTH-1:0][REG_W-1:0] stg_dst;
  logic                        ex_live, dc_live, rf_live, run, issue_vld;
  logic [NUM_SRC-1:0]          ex_dep, dc_hit;
  slip_cause_e                 cause;

  // a producer cancelled in execute never interlocks
  assign ex_live = stg_vld[EX_IDX] & stg_late[EX_IDX] & ~ex_kill_i;
  assign dc_live = stg_vld[DC_IDX] & stg_late[DC_IDX];
  assign rf_live = rf_valid_i & ~rf_kill_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    slip_src_match #(.REG_W(REG_W)) u_match (
      .src_i     (rf_src_i[i]),
      .src_vld_i (rf_src_vld_i[i]),
      .ex_live_i (ex_live),
      .ex_dst_i  (stg_dst[EX_IDX]),
      .dc_live_i (dc_live),
      .dc_dst_i  (stg_dst[DC_IDX]),
      .ex_dep_o  (ex_dep[i]),
      .dc_hit_o  (dc_hit[i])
    );
  end

  always_comb begin
    cause = SLIP_NONE;
    if (rf_live) begin
      if (|ex_dep)                         cause = SLIP_LOAD;
      else if (rf_rd_hilo_i && md_busy_i)  cause = SLIP_MD;
    end
  end

  assign stall_front_o = (cause != SLIP_NONE);
  assign bubble_ex_o   = (cause != SLIP_NONE);
  assign run           = rf_live & (cause == SLIP_NONE);
  assign byp_dc_o      = run ? dc_hit : '0;
  assign hilo_byp_o    = run & rf_rd_hilo_i & md_ready_i;
  // a slipped or killed slot enters execute as a no-op
  assign issue_vld     = run & rf_dst_vld_i;

  slip_stage_track #(.REG_W(REG_W), .DEPTH(DEPTH)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_vld_i    (issue_vld),
    .in_late_i   (rf_late_i),
    .in_dst_i    (rf_dst_i),
    .kill_head_i (ex_kill_i),
    .vld_o       (stg_vld),
    .late_o      (stg_late),
    .dst_o       (stg_dst)
  );
endmodule

// File: rtl/slip_ctrl_chk.sv
module slip_ctrl_chk #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          rf_valid_i,
  input logic                          rf_kill_i,
  input logic                          rf_rd_hilo_i,
  input logic                          md_busy_i,
  input logic [NUM_SRC-1:0][REG_W-1:0] rf_src_i,
  input logic                          stall_front_o,
  input logic                          bubble_ex_o,
  input logic [NUM_SRC-1:0]            byp_dc_o,
  input logic                          hilo_byp_o
);
  // R7
  killed_no_slip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_kill_i |-> !stall_front_o && byp_dc_o == '0 && !hilo_byp_o);

  // R8
  md_busy_slip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_valid_i && !rf_kill_i && rf_rd_hilo_i && md_busy_i |-> stall_front_o && bubble_ex_o);

  // R2
  load_slip_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_front_o && !rf_rd_hilo_i |=> !stall_front_o);

  // R2
  load_slip_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_front_o && !rf_rd_hilo_i |=> (|byp_dc_o) || rf_kill_i || !rf_valid_i);

  // R10
  no_byp_in_slip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_front_o |-> byp_dc_o == '0 && !hilo_byp_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rf_valid_i |-> !stall_front_o && !bubble_ex_o && byp_dc_o == '0 && !hilo_byp_o);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_zero
    // R4
    zero_reg_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byp_dc_o[i] |-> rf_src_i[i] != '0);
  end
endmodule

bind slip_ctrl slip_ctrl_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rf_valid_i    (rf_valid_i),
  .rf_kill_i     (rf_kill_i),
  .rf_rd_hilo_i  (rf_rd_hilo_i),
  .md_busy_i     (md_busy_i),
  .rf_src_i      (rf_src_i),
  .stall_front_o (stall_front_o),
  .bubble_ex_o   (bubble_ex_o),
  .byp_dc_o      (byp_dc_o),
  .hilo_byp_o    (hilo_byp_o)
);

// File: tb/slip_ctrl_bench.sv
module slip_ctrl_bench;
  localparam int REG_W   = 5;
  localparam int NUM_SRC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                          rf_valid, rf_kill, rf_dst_vld, rf_late, rf_hilo;
  logic [NUM_SRC-1:0][REG_W-1:0] rf_src;
  logic [NUM_SRC-1:0]            rf_src_vld;
  logic [REG_W-1:0]              rf_dst;
  logic                          ex_kill, md_busy, md_ready;
  logic                          stall_front, bubble_ex, hilo_byp;
  logic [NUM_SRC-1:0]            byp_dc;

  slip_ctrl #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_slip_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .rf_valid_i(rf_valid), .rf_kill_i(rf_kill), .rf_src_i(rf_src), .rf_src_vld_i(rf_src_vld),
    .rf_dst_i(rf_dst), .rf_dst_vld_i(rf_dst_vld), .rf_late_i(rf_late), .rf_rd_hilo_i(rf_hilo),
    .ex_kill_i(ex_kill), .md_busy_i(md_busy), .md_ready_i(md_ready),
    .stall_front_o(stall_front), .bubble_ex_o(bubble_ex), .byp_dc_o(byp_dc), .hilo_byp_o(hilo_byp)
  );

  int n_chk = 0, n_err = 0, stall_cnt = 0;
  int last_obs;
  logic m_ex_vld, m_ex_late, m_dc_vld, m_dc_late;
  logic [REG_W-1:0] m_ex_dst, m_dc_dst;
  logic e_stall, e_hbyp;
  logic [NUM_SRC-1:0] e_byp;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%05b expected=%05b", tag, act, exp);
    end
  endtask

  // expected outputs from the requirements and the bench's stage model
  function automatic void compute_exp();
    logic live, run;
    logic [NUM_SRC-1:0] dep;
    live  = rf_valid && !rf_kill;
    for (int i = 0; i < NUM_SRC; i++)
      dep[i] = rf_src_vld[i] && rf_src[i] != 0 && m_ex_vld && m_ex_late && !ex_kill
               && m_ex_dst == rf_src[i];
    e_stall = live && ((|dep) || (rf_hilo && md_busy));
    run     = live && !e_stall;
    for (int i = 0; i < NUM_SRC; i++)
      e_byp[i] = run && rf_src_vld[i] && rf_src[i] != 0 && m_dc_vld && m_dc_late
                 && m_dc_dst == rf_src[i];
    e_hbyp = run && rf_hilo && md_ready;
  endfunction

  task automatic step(input string tag);
    #2;
    compute_exp();
    last_obs = int'({stall_front, bubble_ex, byp_dc, hilo_byp});
    if (stall_front) stall_cnt++;
    check(tag, last_obs, int'({e_stall, e_stall, e_byp, e_hbyp}));
    @(posedge clk);
    if (rst_n) begin
      m_dc_vld  = m_ex_vld && !ex_kill;
      m_dc_late = m_ex_late;
      m_dc_dst  = m_ex_dst;
      m_ex_vld  = rf_valid && !rf_kill && !e_stall && rf_dst_vld;
      m_ex_late = rf_late;
      m_ex_dst  = rf_dst;
    end
    @(negedge clk);
  endtask

  task automatic rf(input logic v, input int s0, input logic v0, input int s1, input logic v1,
                    input int d, input logic dv, input logic late, input logic hilo);
    rf_valid = v; rf_src[0] = s0[REG_W-1:0]; rf_src_vld[0] = v0;
    rf_src[1] = s1[REG_W-1:0]; rf_src_vld[1] = v1;
    rf_dst = d[REG_W-1:0]; rf_dst_vld = dv; rf_late = late; rf_hilo = hilo;
    rf_kill = 1'b0; ex_kill = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base, busy_left;
    logic ready_nxt;
    void'($urandom(32'd4021));
    m_ex_vld = 0; m_ex_late = 0; m_ex_dst = 0;
    m_dc_vld = 0; m_dc_late = 0; m_dc_dst = 0;
    md_busy = 0; md_ready = 0;
    rf(1, 3, 1, 4, 1, 3, 1, 1, 0);
    @(negedge clk);
    step("R10 in reset");
    check("R10 reset outputs", last_obs, 0);
    rst_n = 1'b1;
    step("R10 after reset");
    check("R10 first cycle quiet", last_obs, 0);

    // R1 / R2 back-to-back load-use
    rf(1, 1, 1, 2, 1, 5, 1, 1, 0); step("R1 load issue");
    base = stall_cnt;
    rf(1, 5, 1, 0, 0, 6, 1, 0, 0); step("R1 load-use");
    check("R1 slip and bubble", last_obs, 5'b11000);
    step("R2 restart");
    check("R2 dc bypass op0", last_obs, 5'b00010);
    check("R2 one slip cycle", stall_cnt - base, 1);

    // R3 ALU producer, then reader
    rf(1, 1, 1, 0, 0, 7, 1, 0, 0); step("R3 alu issue");
    rf(1, 7, 1, 7, 1, 8, 1, 0, 0); step("R3 alu reader");
    check("R3 no slip after alu", last_obs, 0);
    // R3 source field not valid
    rf(1, 1, 1, 0, 0, 9, 1, 1, 0); step("R3 load issue");
    rf(1, 9, 0, 2, 1, 8, 1, 0, 0); step("R3 invalid field");
    check("R3 unused field no slip", last_obs, 0);

    // R5 distance two
    rf(1, 1, 1, 0, 0, 9, 1, 1, 0); step("R5 load issue");
    rf(1, 1, 1, 2, 1, 3, 1, 0, 0); step("R3 independent");
    check("R3 independent no slip", last_obs, 0);
    rf(1, 4, 1, 9, 1, 3, 1, 0, 0); step("R5 reader");
    check("R5 bypass op1 no slip", last_obs, 5'b00100);

    // R4 register 0 and no-destination producer
    rf(1, 1, 1, 0, 0, 0, 1, 1, 0); step("R4 load r0");
    rf(1, 0, 1, 0, 1, 3, 1, 0, 0); step("R4 reader r0");
    check("R4 r0 no slip", last_obs, 0);
    rf(1, 1, 1, 0, 0, 10, 0, 1, 0); step("R4 no dst");
    rf(1, 10, 1, 0, 0, 3, 1, 0, 0); step("R4 reader");
    check("R4 no-dst no slip", last_obs, 0);
    step("R4 later");
    check("R4 no-dst no bypass", last_obs, 0);

    // R6 producer killed in execute
    rf(1, 1, 1, 0, 0, 11, 1, 1, 0); step("R6 load issue");
    rf(1, 11, 1, 0, 0, 3, 1, 0, 0); ex_kill = 1; step("R6 killed producer");
    check("R6 no slip", last_obs, 0);
    rf(1, 11, 1, 0, 0, 3, 1, 0, 0); step("R6 next reader");
    check("R6 no bypass", last_obs, 0);

    // R7 killed register-fetch instruction
    rf(1, 1, 1, 0, 0, 12, 1, 1, 0); step("R7 load issue");
    rf(1, 12, 1, 0, 0, 13, 1, 1, 0); rf_kill = 1; step("R7 killed reader");
    check("R7 killed no slip", last_obs, 0);
    rf(1, 13, 1, 0, 0, 3, 1, 0, 0); step("R7 reader of killed");
    check("R7 killed issues nothing", last_obs, 0);
    step("R7 later");
    check("R7 no bypass from killed", last_obs, 0);

    // R11 both operands
    rf(1, 1, 1, 0, 0, 14, 1, 1, 0); step("R11 load issue");
    rf(1, 14, 1, 14, 1, 3, 1, 0, 0); step("R11 slip");
    check("R11 slip", last_obs, 5'b11000);
    step("R11 restart");
    check("R11 both bypass", last_obs, 5'b00110);

    // R8 / R9 HI/LO read during busy window
    rf(1, 0, 0, 0, 0, 15, 1, 1, 1); md_busy = 1;
    base = stall_cnt;
    for (int k = 0; k < 3; k++) begin
      step("R8 busy");
      check("R8 slip while busy", last_obs, 5'b11000);
    end
    md_busy = 0; md_ready = 1; step("R9 ready");
    check("R9 hilo bypass", last_obs, 5'b00001);
    check("R8 slip count", stall_cnt - base, 3);
    md_ready = 0; step("R9 idle");
    check("R9 no strobe no bypass", last_obs, 0);

    // random mix
    busy_left = 0; ready_nxt = 0;
    for (int n = 0; n < 4000; n++) begin
      if (!e_stall) begin
        rf($urandom_range(9, 0) != 0, $urandom_range(3, 0), $urandom_range(1, 0),
           $urandom_range(3, 0), $urandom_range(1, 0), $urandom_range(3, 0),
           $urandom_range(4, 0) != 0, $urandom_range(1, 0), $urandom_range(6, 0) == 0);
      end
      rf_kill = ($urandom_range(19, 0) == 0);
      ex_kill = ($urandom_range(19, 0) == 0);
      md_ready = ready_nxt; ready_nxt = 0;
      if (busy_left > 0) begin
        md_busy = 1; busy_left--;
        if (busy_left == 0) ready_nxt = 1;
      end else begin
        md_busy = 0;
        if (!md_ready && $urandom_range(7, 0) == 0) begin
          busy_left = $urandom_range(4, 1);
          md_busy = 1; busy_left--;
          if (busy_left == 0) ready_nxt = 1;
        end
      end
      step("R1 R5 R8 random mix");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule